// File: doc/BRIEF.md
# Request Parity Checker with Retry

This block sits beside one agent on a shared multi-agent system bus and guards the request phase. On every cycle in which the active-low address strobe is sampled low, it checks two address parity bits and one request parity bit against the address and request-type fields. If any of the three does not match and driving is enabled, the block pulls the shared open-drain address-error line low for one bus clock, a fixed two clocks after the strobe.

The block also watches the wired error line, whether this agent or another agent pulls it. When observation is enabled and the line is low in the error window of a transaction, the block cancels that transaction. It also emits a pulse that tells the arbiter to return its rotating priority to the reset state, in which agent 0 ranks highest. The same cancel pulse tells the snoop logic to drop that transaction's results. If this agent issued the cancelled transaction, a retry counter either asks for a reissue or, once the configured limit is used up, reports a hard error. A successful completion clears the counter.

Two power-on configuration inputs select the modes: one enables driving of the error line and one enables observation of it. They are expected to stay constant between transactions.

Top module: `reqpar_guard`

## Requirements
- R1: With driving enabled, the block pulls the error line when any check fails. Address parity bit 0 covers the lower half of the address. Address parity bit 1 covers the upper half. The request parity bit covers the request-type field and the strobe. Every group, together with its parity bit, must hold an even number of ones in its active-low levels.
- R2: With driving disabled, `err_pull` stays 0 whatever the parity inputs are.
- R3: `err_pull` is high for exactly one cycle. If the strobe is low in cycle c, the pulse is in cycle c+2, and `err_pull` is 0 in cycles c+1 and c+3.
- R4: With observation enabled, a low `err_line_n` in cycle c+2 produces a one-cycle pulse on both `cancel` and `rotor_reset` in cycle c+3. The line may be pulled by this agent or by another one.
- R5: With observation disabled, `cancel`, `rotor_reset`, `retry_req` and `hard_err` stay 0 even when the error line is low.
- R6: A cancel of this agent's transaction (`own_req` high with the strobe) while `retry_cnt` is below RETRY_LIMIT pulses `retry_req` and increments `retry_cnt` in cycle c+3.
- R7: A cancel of this agent's transaction while `retry_cnt` equals RETRY_LIMIT pulses `hard_err` instead of `retry_req` and returns `retry_cnt` to 0. The default limit is 3.
- R8: A `txn_done` pulse clears `retry_cnt` on the next cycle.
- R9: A cancel of a transaction this agent did not issue leaves `retry_cnt` unchanged and raises neither `retry_req` nor `hard_err`.
- R10: During and directly after reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_drive_en | input | 1 | Power-on bit that enables driving of the error line |
| cfg_observe_en | input | 1 | Power-on bit that enables observation of the error line |
| strobe_n | input | 1 | Active-low address strobe that marks the start of a request |
| addr_n | input | ADDR_W | Active-low request address |
| reqtype_n | input | REQ_W | Active-low request-type field |
| apar_n | input | 2 | Active-low address parity: bit 0 for the lower half, bit 1 for the upper half |
| rpar_n | input | 1 | Active-low request parity |
| own_req | input | 1 | High with the strobe when this agent issued the request |
| txn_done | input | 1 | Pulse on successful completion of this agent's transaction |
| err_line_n | input | 1 | Sampled level of the wired open-drain error line |
| err_pull | output | 1 | High to pull the error line low |
| cancel | output | 1 | Transaction cancelled; snoop results are dropped |
| rotor_reset | output | 1 | Arbiter must reset its rotating priority |
| retry_req | output | 1 | Reissue of this agent's cancelled transaction is requested |
| hard_err | output | 1 | Retry limit is used up; the failure is a hard error |
| retry_cnt | output | CNT_W | Retries used for the current transaction |

## Verification
The assertions check the following on every cycle. Every error pulse traces back to a strobe two cycles earlier under driving enabled. Every cancel traces back to a low error line with observation enabled. A retry always raises the count by one, and a hard error occurs only at the limit. The two never occur together, and a completion clears the count. Only the bench's scenarios can show parity coverage, because that needs known-good and corrupted parity for each group. The same holds for the exact cycle of each pulse, counter escalation across repeated cancels of one transaction, and a cancel from another agent leaving this agent's count untouched.

// File: rtl/reqpar_pkg.sv
package reqpar_pkg;
   // One flag per parity group: set means that group failed its check
   typedef struct packed {
      logic addr_hi;
      logic addr_lo;
      logic req;
   } par_fail_t;

   localparam int unsigned PIPE_TO_PULL = 2;
endpackage

// File: rtl/reqpar_parity.sv
module reqpar_parity
   import reqpar_pkg::*;
#(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned REQ_W  = 5
) (
   input  logic [ADDR_W-1:0] addr_n,
   input  logic [REQ_W-1:0]  reqtype_n,
   input  logic              strobe_n,
   input  logic [1:0]        apar_n,
   input  logic              rpar_n,
   output par_fail_t         fail
);
   localparam int unsigned HALF_W = ADDR_W / 2;

   initial begin
      if (ADDR_W < 2 || (ADDR_W % 2) != 0)
         $error("reqpar_parity: ADDR_W must be even and at least 2");
      if (REQ_W < 1)
         $error("reqpar_parity: REQ_W must be at least 1");
   end

   logic [1:0] half_bad;

   // Even parity over active-low levels: the group XOR with its bit must be 0
   for (genvar h = 0; h < 2; h++) begin : g_half
      assign half_bad[h] = ^{addr_n[h*HALF_W +: HALF_W], apar_n[h]};
   end

   assign fail.addr_lo = half_bad[0];
   assign fail.addr_hi = half_bad[1];
   assign fail.req     = ^{reqtype_n, strobe_n, rpar_n};
endmodule

// File: rtl/reqpar_window.sv
module reqpar_window (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe_n,
   input  logic bad,
   input  logic own_req,
   output logic err_pull,
   output logic win,
   output logic win_own
);
   logic st_vld, st_bad, st_own;

   // Stage 1: capture at the strobe edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_vld <= 1'b0;
         st_bad <= 1'b0;
         st_own <= 1'b0;
      end else begin
         st_vld <= !strobe_n;
         st_bad <= !strobe_n && bad;
         st_own <= !strobe_n && own_req;
      end
   end

   // Stage 2: error pulse and observation window, two clocks after the strobe
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_pull <= 1'b0;
         win      <= 1'b0;
         win_own  <= 1'b0;
      end else begin
         err_pull <= st_vld && st_bad;
         win      <= st_vld;
         win_own  <= st_vld && st_own;
      end
   end

   a_r3_pull_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      err_pull |-> $past(!strobe_n, 2));
endmodule

// File: rtl/reqpar_retry.sv
module reqpar_retry #(
   parameter int unsigned CNT_W       = 4,
   parameter int unsigned RETRY_LIMIT = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             own_cancel,
   input  logic             txn_done,
   output logic             retry_req,
   output logic             hard_err,
   output logic [CNT_W-1:0] retry_cnt
);
   localparam int unsigned CNT_MAX = (1 << CNT_W) - 1;
   localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(RETRY_LIMIT);

   initial begin
      if (CNT_W < 1 || CNT_W > 16)
         $error("reqpar_retry: CNT_W out of range");
      if (RETRY_LIMIT > CNT_MAX)
         $error("reqpar_retry: RETRY_LIMIT does not fit in CNT_W bits");
   end

   if (RETRY_LIMIT == 0) begin : g_no_retry
      // Every own cancel is immediately a hard error
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) hard_err <= 1'b0;
         else        hard_err <= own_cancel;
      end
      assign retry_req = 1'b0;
      assign retry_cnt = '0;
   end else begin : g_counted
      logic             rq_q, he_q;
      logic [CNT_W-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rq_q  <= 1'b0;
            he_q  <= 1'b0;
            cnt_q <= '0;
         end else begin
            rq_q <= 1'b0;
            he_q <= 1'b0;
            if (own_cancel) begin
               if (cnt_q < LIMIT_V) begin
                  rq_q  <= 1'b1;
                  cnt_q <= cnt_q + 1'b1;
               end else begin
                  he_q  <= 1'b1;
                  cnt_q <= '0;
               end
            end else if (txn_done) begin
               cnt_q <= '0;
            end
         end
      end
      assign retry_req = rq_q;
      assign hard_err  = he_q;
      assign retry_cnt = cnt_q;
   end

   a_r6_retry_steps: assert property (@(posedge clk) disable iff (!rst_n)
      retry_req |-> retry_cnt == $past(retry_cnt) + 1'b1);
   a_r7_hard_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
      hard_err |-> ($past(retry_cnt) == LIMIT_V && retry_cnt == '0));
   a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(retry_req && hard_err));
   a_r8_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (txn_done && !own_cancel) |=> retry_cnt == '0);
endmodule

// File: rtl/reqpar_guard.sv
module reqpar_guard
   import reqpar_pkg::*;
#(
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned REQ_W       = 5,
   parameter int unsigned CNT_W       = 4,
   parameter int unsigned RETRY_LIMIT = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_drive_en,
   input  logic              cfg_observe_en,
   input  logic              strobe_n,
   input  logic [ADDR_W-1:0] addr_n,
   input  logic [REQ_W-1:0]  reqtype_n,
   input  logic [1:0]        apar_n,
   input  logic              rpar_n,
   input  logic              own_req,
   input  logic              txn_done,
   input  logic              err_line_n,
   output logic              err_pull,
   output logic              cancel,
   output logic              rotor_reset,
   output logic              retry_req,
   output logic              hard_err,
   output logic [CNT_W-1:0]  retry_cnt
);
   par_fail_t fail;
   logic      bad, win, win_own, hit, own_cancel;

   reqpar_parity #(.ADDR_W(ADDR_W), .REQ_W(REQ_W)) u_parity (
      .addr_n    (addr_n),
      .reqtype_n (reqtype_n),
      .strobe_n  (strobe_n),
      .apar_n    (apar_n),
      .rpar_n    (rpar_n),
      .fail      (fail)
   );

   assign bad = cfg_drive_en && (fail.addr_lo || fail.addr_hi || fail.req);

   reqpar_window u_window (
      .clk      (clk),
      .rst_n    (rst_n),
      .strobe_n (strobe_n),
      .bad      (bad),
      .own_req  (own_req),
      .err_pull (err_pull),
      .win      (win),
      .win_own  (win_own)
   );

   // Observation: the wired line is sampled only in the error window
   assign hit        = win && cfg_observe_en && !err_line_n;
   assign own_cancel = hit && win_own;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cancel      <= 1'b0;
         rotor_reset <= 1'b0;
      end else begin
         cancel      <= hit;
         rotor_reset <= hit;
      end
   end

   reqpar_retry #(.CNT_W(CNT_W), .RETRY_LIMIT(RETRY_LIMIT)) u_retry (
      .clk        (clk),
      .rst_n      (rst_n),
      .own_cancel (own_cancel),
      .txn_done   (txn_done),
      .retry_req  (retry_req),
      .hard_err   (hard_err),
      .retry_cnt  (retry_cnt)
   );

   a_r4_cancel_from_line: assert property (@(posedge clk) disable iff (!rst_n)
      cancel |-> $past(!err_line_n));
   a_r5_cancel_needs_observe: assert property (@(posedge clk) disable iff (!rst_n)
      cancel |-> $past(cfg_observe_en));
   a_r2_pull_needs_drive: assert property (@(posedge clk) disable iff (!rst_n)
      err_pull |-> $past(cfg_drive_en, 2));
   a_r9_retry_follows_cancel: assert property (@(posedge clk) disable iff (!rst_n)
      (retry_req || hard_err) |-> cancel);
endmodule

// File: tb/reqpar_guard_bench.sv
module reqpar_guard_bench;
   localparam int unsigned CLK_PERIOD = 10;
   localparam int unsigned AW = 8;
   localparam int unsigned RW = 5;
   localparam int unsigned CW = 4;
   localparam int unsigned LIM = 3;
   localparam int unsigned NVEC = 10;

   // {addr_n, reqtype_n, flip[2:0] = {req, hi, lo}, drive, observe, ext, exp_pull, exp_cancel}
   localparam logic [20:0] VEC [NVEC] = '{
      {8'hA5, 5'h0B, 3'b000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
      {8'h3C, 5'h11, 3'b001, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1},
      {8'hF0, 5'h1F, 3'b010, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1},
      {8'h01, 5'h06, 3'b100, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1},
      {8'h7E, 5'h00, 3'b011, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
      {8'h96, 5'h15, 3'b001, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
      {8'h55, 5'h0A, 3'b000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1},
      {8'hC3, 5'h1C, 3'b000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
      {8'hFF, 5'h1F, 3'b111, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1},
      {8'h00, 5'h00, 3'b000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic cfg_drive_en = 1'b0, cfg_observe_en = 1'b0;
   logic strobe_n = 1'b1, rpar_n = 1'b0, own_req = 1'b0, txn_done = 1'b0;
   logic ext_n = 1'b1;
   logic [AW-1:0] addr_n = '0;
   logic [RW-1:0] reqtype_n = '0;
   logic [1:0]    apar_n = '0;
   logic err_line_n, err_pull, cancel, rotor_reset, retry_req, hard_err;
   logic [CW-1:0] retry_cnt;
   int checks = 0, fails = 0;
   bit done = 1'b0;

   // Wired-AND open-drain line: this agent plus an external agent
   assign err_line_n = !err_pull && ext_n;

   always #(CLK_PERIOD/2) clk = !clk;

   reqpar_guard #(.ADDR_W(AW), .REQ_W(RW), .CNT_W(CW), .RETRY_LIMIT(LIM)) u_reqpar_guard (
      .clk(clk), .rst_n(rst_n), .cfg_drive_en(cfg_drive_en), .cfg_observe_en(cfg_observe_en),
      .strobe_n(strobe_n), .addr_n(addr_n), .reqtype_n(reqtype_n), .apar_n(apar_n),
      .rpar_n(rpar_n), .own_req(own_req), .txn_done(txn_done), .err_line_n(err_line_n),
      .err_pull(err_pull), .cancel(cancel), .rotor_reset(rotor_reset), .retry_req(retry_req),
      .hard_err(hard_err), .retry_cnt(retry_cnt)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // One request: strobe in cycle c, check c+1, c+2 (pulse), c+3 (results)
   task automatic txn(input logic [AW-1:0] a, input logic [RW-1:0] rt, input logic [2:0] flip,
                      input logic own, input logic ext, input logic exp_pull, input logic exp_cancel,
                      input logic exp_retry, input logic exp_hard, input int exp_cnt);
      @(negedge clk);
      addr_n    = a;
      reqtype_n = rt;
      apar_n    = {^a[AW-1:AW/2] ^ flip[1], ^a[AW/2-1:0] ^ flip[0]};
      rpar_n    = ^rt ^ flip[2];
      own_req   = own;
      strobe_n  = 1'b0;
      @(negedge clk);
      strobe_n = 1'b1;
      own_req  = 1'b0;
      check("R3 no pull in c+1", err_pull, 0);
      @(negedge clk);
      check("R1/R2/R3 pull in c+2", err_pull, exp_pull);
      ext_n = !ext;
      @(negedge clk);
      ext_n = 1'b1;
      check("R3 no pull in c+3", err_pull, 0);
      check("R4/R5 cancel", cancel, exp_cancel);
      check("R4/R5 rotor_reset", rotor_reset, exp_cancel);
      check("R6/R9 retry_req", retry_req, exp_retry);
      check("R7/R9 hard_err", hard_err, exp_hard);
      check("R6/R7/R9 retry_cnt", retry_cnt, exp_cnt);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R10 reset err_pull", err_pull, 0);
      check("R10 reset cancel", cancel, 0);
      check("R10 reset retry_cnt", retry_cnt, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R10 after reset outputs", {err_pull, cancel, rotor_reset, retry_req, hard_err}, 0);

      // Table walk: R1 R2 R3 R4 R5, non-own transactions
      for (int i = 0; i < NVEC; i++) begin
         cfg_drive_en   = VEC[i][4];
         cfg_observe_en = VEC[i][3];
         txn(VEC[i][20:13], VEC[i][12:8], VEC[i][7:5], 1'b0, VEC[i][2],
             VEC[i][1], VEC[i][0], 1'b0, 1'b0, 0);
      end

      cfg_drive_en   = 1'b1;
      cfg_observe_en = 1'b1;
      // R6 and R7: repeated cancels of own transaction escalate
      for (int k = 1; k <= LIM; k++)
         txn(8'h5A, 5'h03, 3'b001, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, k);
      txn(8'h5A, 5'h03, 3'b001, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 0);
      @(negedge clk);
      check("R4 cancel is one cycle", cancel, 0);
      check("R7 hard_err is one cycle", hard_err, 0);

      // R8: completion clears the count
      txn(8'h21, 5'h04, 3'b010, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1);
      @(negedge clk);
      txn_done = 1'b1;
      @(negedge clk);
      txn_done = 1'b0;
      check("R8 txn_done clears retry_cnt", retry_cnt, 0);

      // R9: another agent's cancelled request leaves the count alone
      txn(8'h21, 5'h04, 3'b010, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1);
      txn(8'h88, 5'h09, 3'b000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1);

      // R2: drive off, own request with bad parity and no external error
      cfg_drive_en = 1'b0;
      txn(8'h42, 5'h12, 3'b101, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1);

      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule